// File: doc/BRIEF.md
# Running-Priority Register Read Access Decoder

This block decides what happens when software executes a read of the running-priority system register of an interrupt controller CPU interface. It takes the instruction's system-register encoding, the exception level the read comes from and the control state of the core: debug halt, secure debug disable, whether EL2 and EL3 exist, the EL3 interrupt routing bits, the per-level register-enable bits, the EL2 common-trap bit and the EL2 interrupt virtualization bits. From these it produces a single outcome: the access is undefined, it traps to EL1, EL2 or EL3 with an exception class, it is redirected to the virtual register, or the physical register is read. Encodings that do not name this register are reported as not matched.

The checks run in a fixed priority order, and that order differs for each exception level. A debug-halt case can make a read undefined ahead of every trap. An implementation option, set by a parameter, decides whether that early undefined check exists. The outcome is registered and appears one cycle after a valid request. The register value itself is produced elsewhere.

Top module: `rprio_access_decoder`

## Requirements
- R1: While `rstN` is low, `rspValid`, `rspCode`, `rspTarget` and `rspSyndrome` are all zero.
- R2: A request with `reqValid` high at a rising edge gives `rspValid` high and exactly one bit set in `rspCode` after that edge, for one cycle. When `reqValid` is low at an edge, `rspValid` is low after that edge and `rspCode`, `rspTarget` and `rspSyndrome` keep their values.
- R3: The register is selected only by `reqEnc` = 16'hC65B, which is {op0 2'b11, op1 3'b000, CRn 4'b1100, CRm 4'b1011, op2 3'b011} with op0 in the top bits. Any other encoding gives `rspCode` = 5'b10000 (no match), with target 0 and syndrome 0, whatever the other inputs are.
- R4: `rspCode` is one-hot: bit0 undefined, bit1 trap, bit2 virtual read, bit3 physical read, bit4 no match. A matching read with `curLevel` = 0 (EL0) is always undefined.
- R5: At EL1 and EL2, when the parameter `TRAP_PRIO_OPT` is 1, a read is undefined ahead of all other checks if `debugHalted`, `secDebugDis`, `el3Present`, `el3IrqRoute` and `el3FiqRoute` are all 1. With `TRAP_PRIO_OPT` = 0 this early check is absent.
- R6: At EL1, if the R5 case does not apply and `enEl1` is 0, the read traps to EL1 (`rspTarget` = 1), ahead of every EL2 and EL3 check.
- R7: At EL1, after R6, if EL2 is present and `el2TrapCommon` is 1, the read traps to EL2 (`rspTarget` = 2), ahead of virtualization.
- R8: At EL1, after R7, if EL2 is present and `el2FiqVirt` or `el2IrqVirt` is 1, the virtual register is read, ahead of the EL3 routing check.
- R9: At EL1 and EL2, after the level's earlier checks, if EL3 is present and both routing bits are 1, the read traps to EL3 (`rspTarget` = 3), or is undefined when `debugHalted` and `secDebugDis` are both 1. If neither routing bit pair nor any earlier check applies, the physical register is read.
- R10: At EL2, after R5, `enEl2` = 0 traps to EL2 ahead of the EL3 routing check. The EL2 common-trap and virtualization bits have no effect on reads from EL2.
- R11: At EL3, `enEl3` = 0 traps to EL3 and otherwise the physical register is read. Debug halt, routing and EL2 bits have no effect there.
- R12: Every trap reports `rspSyndrome` = 6'h18. Every other outcome reports syndrome 0 and `rspTarget` 0.
- R13: With `el2Present` = 0, the EL2 common-trap and virtualization bits have no effect on reads from EL1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A read request is presented this cycle |
| reqEnc | input | 16 | System-register encoding {op0, op1, CRn, CRm, op2} |
| curLevel | input | 2 | Exception level of the read, 0 to 3 |
| debugHalted | input | 1 | Core is in halted debug state |
| secDebugDis | input | 1 | Secure self-hosted debug is disabled |
| el2Present | input | 1 | EL2 is implemented and enabled |
| el3Present | input | 1 | EL3 is implemented |
| el3IrqRoute | input | 1 | EL3 takes IRQs |
| el3FiqRoute | input | 1 | EL3 takes FIQs |
| enEl1 | input | 1 | System-register interface enable for EL1 |
| enEl2 | input | 1 | System-register interface enable for EL2 |
| enEl3 | input | 1 | System-register interface enable for EL3 |
| el2TrapCommon | input | 1 | EL2 traps common interrupt-controller register reads |
| el2FiqVirt | input | 1 | EL2 virtualizes FIQs |
| el2IrqVirt | input | 1 | EL2 virtualizes IRQs |
| rspValid | output | 1 | Outcome is valid this cycle |
| rspCode | output | 5 | One-hot outcome code |
| rspTarget | output | 2 | Trap target level, 0 when not a trap |
| rspSyndrome | output | 6 | Exception class of a trap, 0 otherwise |

## Verification
Every outcome is due exactly one rising edge after the edge that samples `reqValid`. The bench drives a request at a falling edge, drops `reqValid` at the next falling edge and reads the outcome there, half a cycle after the edge that registered it. The check that outputs hold is made one and two cycles later with `reqValid` low. A second instance with the early debug check disabled sees the same inputs, so the cases where the two priority orders differ are compared in the same cycle.

// File: rtl/rprio_access_pkg.sv
package rprio_access_pkg;

  localparam int CODE_W = 5;
  localparam int LVL_W  = 2;

  // one-hot outcome bit positions
  localparam int BIT_UNDEF = 0;
  localparam int BIT_TRAP  = 1;
  localparam int BIT_VIRT  = 2;
  localparam int BIT_PHYS  = 3;
  localparam int BIT_NOHIT = 4;

  typedef enum logic [LVL_W-1:0] {
    LVL_EL0 = 2'd0,
    LVL_EL1 = 2'd1,
    LVL_EL2 = 2'd2,
    LVL_EL3 = 2'd3
  } excLevel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             undef;
    logic             trap;
    logic             virt;
    logic             phys;
    logic             noHit;
    logic [LVL_W-1:0] tgtLevel;
  } ctrlStrobes_t;

endpackage

// File: rtl/rprio_access_ctrl.sv
module rprio_access_ctrl
  import rprio_access_pkg::*;
#(
  parameter int                ENC_W         = 16,
  parameter logic [ENC_W-1:0]  MATCH_ENC     = 16'hC65B,
  parameter int                TRAP_PRIO_OPT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ENC_W-1:0] reqEnc,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             debugHalted,
  input  logic             secDebugDis,
  input  logic             el2Present,
  input  logic             el3Present,
  input  logic             el3IrqRoute,
  input  logic             el3FiqRoute,
  input  logic             enEl1,
  input  logic             enEl2,
  input  logic             enEl3,
  input  logic             el2TrapCommon,
  input  logic             el2FiqVirt,
  input  logic             el2IrqVirt,
  output ctrlStrobes_t     strobes
);

  localparam logic PRIO_BIT = (TRAP_PRIO_OPT != 0);

  logic encHit;
  logic bothRoutes;
  logic haltSdd;
  logic dbgUndef;
  logic el2Trap;
  logic el2Virt;

  assign encHit     = (reqEnc == MATCH_ENC);
  assign bothRoutes = el3Present & el3IrqRoute & el3FiqRoute;
  assign haltSdd    = debugHalted & secDebugDis;
  assign dbgUndef   = PRIO_BIT & haltSdd & bothRoutes;
  // EL2 conditions are false when EL2 is absent
  assign el2Trap    = el2Present & el2TrapCommon;
  assign el2Virt    = el2Present & (el2FiqVirt | el2IrqVirt);

  always_comb begin
    strobes      = '0;
    strobes.load = reqValid;
    if (!encHit) begin
      strobes.noHit = 1'b1;
    end else begin
      case (excLevel_e'(curLevel))
        LVL_EL0: strobes.undef = 1'b1;
        LVL_EL1: begin
          if (dbgUndef) begin
            strobes.undef = 1'b1;
          end else if (!enEl1) begin
            strobes.trap     = 1'b1;
            strobes.tgtLevel = LVL_EL1;
          end else if (el2Trap) begin
            strobes.trap     = 1'b1;
            strobes.tgtLevel = LVL_EL2;
          end else if (el2Virt) begin
            strobes.virt = 1'b1;
          end else if (bothRoutes) begin
            if (haltSdd) begin
              strobes.undef = 1'b1;
            end else begin
              strobes.trap     = 1'b1;
              strobes.tgtLevel = LVL_EL3;
            end
          end else begin
            strobes.phys = 1'b1;
          end
        end
        LVL_EL2: begin
          if (dbgUndef) begin
            strobes.undef = 1'b1;
          end else if (!enEl2) begin
            strobes.trap     = 1'b1;
            strobes.tgtLevel = LVL_EL2;
          end else if (bothRoutes) begin
            if (haltSdd) begin
              strobes.undef = 1'b1;
            end else begin
              strobes.trap     = 1'b1;
              strobes.tgtLevel = LVL_EL3;
            end
          end else begin
            strobes.phys = 1'b1;
          end
        end
        default: begin
          if (!enEl3) begin
            strobes.trap     = 1'b1;
            strobes.tgtLevel = LVL_EL3;
          end else begin
            strobes.phys = 1'b1;
          end
        end
      endcase
    end
  end

  // R4: EL0 reads of the register are never anything but undefined
  p_el0_undef_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && encHit && curLevel == LVL_EL0) |-> (strobes.undef && !strobes.trap));

  // R13: with EL2 absent, EL1 never reaches EL2 trap or virtual read
  p_no_el2_r13: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !el2Present && curLevel == LVL_EL1)
      |-> !strobes.virt && !(strobes.trap && strobes.tgtLevel == LVL_EL2));

  // R11: EL3 reads never redirect to the virtual register or become undefined
  p_el3_plain_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && encHit && curLevel == LVL_EL3) |-> !strobes.virt && !strobes.undef);

  // R3: a non-matching encoding yields no other outcome
  p_nohit_alone_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !encHit) |-> !(strobes.undef | strobes.trap | strobes.virt | strobes.phys));

endmodule

// File: rtl/rprio_access_dp.sv
module rprio_access_dp
  import rprio_access_pkg::*;
#(
  parameter int               SYN_W   = 6,
  parameter logic [SYN_W-1:0] TRAP_EC = 6'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic              rspValid,
  output logic [CODE_W-1:0] rspCode,
  output logic [LVL_W-1:0]  rspTarget,
  output logic [SYN_W-1:0]  rspSyndrome
);

  logic [CODE_W-1:0] nextCode;

  always_comb begin
    nextCode            = '0;
    nextCode[BIT_UNDEF] = strobes.undef;
    nextCode[BIT_TRAP]  = strobes.trap;
    nextCode[BIT_VIRT]  = strobes.virt;
    nextCode[BIT_PHYS]  = strobes.phys;
    nextCode[BIT_NOHIT] = strobes.noHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspCode     <= '0;
      rspTarget   <= '0;
      rspSyndrome <= '0;
    end else begin
      rspValid <= strobes.load;
      if (strobes.load) begin
        rspCode     <= nextCode;
        rspTarget   <= strobes.trap ? strobes.tgtLevel : '0;
        rspSyndrome <= strobes.trap ? TRAP_EC : '0;
      end
    end
  end

  // R2: every response carries exactly one outcome
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones(rspCode) == 1));

  // R12: traps carry the fixed class and a nonzero target
  p_trap_class_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode[BIT_TRAP]) |-> (rspSyndrome == TRAP_EC && rspTarget != '0));

  // R12: non-trap outcomes carry no class and no target
  p_quiet_class_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspCode[BIT_TRAP]) |-> (rspSyndrome == '0 && rspTarget == '0));

  // R2: outputs hold while no request is sampled
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(rspCode) && $stable(rspTarget) && $stable(rspSyndrome) && !rspValid));

endmodule

// File: rtl/rprio_access_decoder.sv
module rprio_access_decoder
  import rprio_access_pkg::*;
#(
  parameter int TRAP_PRIO_OPT = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [15:0] reqEnc,
  input  logic [1:0]  curLevel,
  input  logic        debugHalted,
  input  logic        secDebugDis,
  input  logic        el2Present,
  input  logic        el3Present,
  input  logic        el3IrqRoute,
  input  logic        el3FiqRoute,
  input  logic        enEl1,
  input  logic        enEl2,
  input  logic        enEl3,
  input  logic        el2TrapCommon,
  input  logic        el2FiqVirt,
  input  logic        el2IrqVirt,
  output logic        rspValid,
  output logic [4:0]  rspCode,
  output logic [1:0]  rspTarget,
  output logic [5:0]  rspSyndrome
);

  ctrlStrobes_t strobes;

  rprio_access_ctrl #(
    .ENC_W(16), .MATCH_ENC(16'hC65B), .TRAP_PRIO_OPT(TRAP_PRIO_OPT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnc(reqEnc),
    .curLevel(curLevel), .debugHalted(debugHalted), .secDebugDis(secDebugDis),
    .el2Present(el2Present), .el3Present(el3Present),
    .el3IrqRoute(el3IrqRoute), .el3FiqRoute(el3FiqRoute),
    .enEl1(enEl1), .enEl2(enEl2), .enEl3(enEl3),
    .el2TrapCommon(el2TrapCommon), .el2FiqVirt(el2FiqVirt), .el2IrqVirt(el2IrqVirt),
    .strobes(strobes)
  );

  rprio_access_dp #(
    .SYN_W(6), .TRAP_EC(6'h18)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rspValid(rspValid), .rspCode(rspCode),
    .rspTarget(rspTarget), .rspSyndrome(rspSyndrome)
  );

endmodule

// File: tb/rprio_access_decoder_tb_top.sv
`timescale 1ns/1ps
module rprio_access_decoder_tb_top;

  localparam logic [15:0] HIT = 16'hC65B;
  localparam logic [4:0] CU = 5'b00001, CT = 5'b00010, CV = 5'b00100,
                         CP = 5'b01000, CN = 5'b10000;
  localparam int NV = 30;
  // {lvl, flags{halted,sdd,el2p,el3p,irq,fiq,en1,en2,en3,tc,fv,iv},
  //  code opt1, tgt opt1, code opt0, tgt opt0, requirement}
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 12'b001100111000, CU, 2'd0, CU, 2'd0, 4'd4},   // R4
    {2'd0, 12'b001100000000, CU, 2'd0, CU, 2'd0, 4'd4},   // R4
    {2'd1, 12'b001100111000, CP, 2'd0, CP, 2'd0, 4'd9},   // R9
    {2'd1, 12'b111111111000, CU, 2'd0, CU, 2'd0, 4'd5},   // R5
    {2'd1, 12'b111111011000, CU, 2'd0, CT, 2'd1, 4'd5},   // R5
    {2'd1, 12'b111011111000, CP, 2'd0, CP, 2'd0, 4'd5},   // R5
    {2'd1, 12'b001100011000, CT, 2'd1, CT, 2'd1, 4'd6},   // R6
    {2'd1, 12'b001100011100, CT, 2'd1, CT, 2'd1, 4'd6},   // R6
    {2'd1, 12'b000000011000, CT, 2'd1, CT, 2'd1, 4'd6},   // R6
    {2'd1, 12'b001100111100, CT, 2'd2, CT, 2'd2, 4'd7},   // R7
    {2'd1, 12'b001100111101, CT, 2'd2, CT, 2'd2, 4'd7},   // R7
    {2'd1, 12'b000100111100, CP, 2'd0, CP, 2'd0, 4'd13},  // R13
    {2'd1, 12'b000100111001, CP, 2'd0, CP, 2'd0, 4'd13},  // R13
    {2'd1, 12'b001100111010, CV, 2'd0, CV, 2'd0, 4'd8},   // R8
    {2'd1, 12'b001100111001, CV, 2'd0, CV, 2'd0, 4'd8},   // R8
    {2'd1, 12'b001111111010, CV, 2'd0, CV, 2'd0, 4'd8},   // R8
    {2'd1, 12'b001111111000, CT, 2'd3, CT, 2'd3, 4'd9},   // R9
    {2'd1, 12'b001110111000, CP, 2'd0, CP, 2'd0, 4'd9},   // R9
    {2'd1, 12'b001101111000, CP, 2'd0, CP, 2'd0, 4'd9},   // R9
    {2'd2, 12'b001100111000, CP, 2'd0, CP, 2'd0, 4'd10},  // R10
    {2'd2, 12'b001100101000, CT, 2'd2, CT, 2'd2, 4'd10},  // R10
    {2'd2, 12'b001111101000, CT, 2'd2, CT, 2'd2, 4'd10},  // R10
    {2'd2, 12'b001100111110, CP, 2'd0, CP, 2'd0, 4'd10},  // R10
    {2'd2, 12'b001111111000, CT, 2'd3, CT, 2'd3, 4'd9},   // R9
    {2'd2, 12'b111111111000, CU, 2'd0, CU, 2'd0, 4'd5},   // R5
    {2'd2, 12'b111111101000, CU, 2'd0, CT, 2'd2, 4'd5},   // R5
    {2'd3, 12'b001100111000, CP, 2'd0, CP, 2'd0, 4'd11},  // R11
    {2'd3, 12'b001100110000, CT, 2'd3, CT, 2'd3, 4'd11},  // R11
    {2'd3, 12'b111111111000, CP, 2'd0, CP, 2'd0, 4'd11},  // R11
    {2'd1, 12'b101111111000, CT, 2'd3, CT, 2'd3, 4'd9}    // R9
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqEnc = '0;
  logic [1:0] curLevel = '0;
  logic debugHalted = 0, secDebugDis = 0, el2Present = 0, el3Present = 0;
  logic el3IrqRoute = 0, el3FiqRoute = 0, enEl1 = 0, enEl2 = 0, enEl3 = 0;
  logic el2TrapCommon = 0, el2FiqVirt = 0, el2IrqVirt = 0;

  logic rspValid1, rspValid0;
  logic [4:0] rspCode1, rspCode0;
  logic [1:0] rspTarget1, rspTarget0;
  logic [5:0] rspSyndrome1, rspSyndrome0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rprio_access_decoder #(.TRAP_PRIO_OPT(1)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnc(reqEnc), .curLevel(curLevel),
    .debugHalted(debugHalted), .secDebugDis(secDebugDis), .el2Present(el2Present),
    .el3Present(el3Present), .el3IrqRoute(el3IrqRoute), .el3FiqRoute(el3FiqRoute),
    .enEl1(enEl1), .enEl2(enEl2), .enEl3(enEl3), .el2TrapCommon(el2TrapCommon),
    .el2FiqVirt(el2FiqVirt), .el2IrqVirt(el2IrqVirt),
    .rspValid(rspValid1), .rspCode(rspCode1), .rspTarget(rspTarget1), .rspSyndrome(rspSyndrome1)
  );

  rprio_access_decoder #(.TRAP_PRIO_OPT(0)) dut0_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnc(reqEnc), .curLevel(curLevel),
    .debugHalted(debugHalted), .secDebugDis(secDebugDis), .el2Present(el2Present),
    .el3Present(el3Present), .el3IrqRoute(el3IrqRoute), .el3FiqRoute(el3FiqRoute),
    .enEl1(enEl1), .enEl2(enEl2), .enEl3(enEl3), .el2TrapCommon(el2TrapCommon),
    .el2FiqVirt(el2FiqVirt), .el2IrqVirt(el2IrqVirt),
    .rspValid(rspValid0), .rspCode(rspCode0), .rspTarget(rspTarget0), .rspSyndrome(rspSyndrome0)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setFlags(input logic [1:0] lvl, input logic [11:0] f);
    curLevel = lvl;
    {debugHalted, secDebugDis, el2Present, el3Present, el3IrqRoute, el3FiqRoute,
     enEl1, enEl2, enEl3, el2TrapCommon, el2FiqVirt, el2IrqVirt} = f;
  endtask

  // drive at a falling edge, registered at the next rising edge, read at the following falling edge
  task automatic request(input logic [15:0] enc, input logic [1:0] lvl, input logic [11:0] f);
    @(negedge clk);
    reqEnc = enc;
    setFlags(lvl, f);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [5:0] synOf(input logic [4:0] c);
    return (c == CT) ? 6'h18 : 6'h00;
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with requests present
    reqValid = 1'b1;
    reqEnc = HIT;
    setFlags(2'd1, 12'b001100111000);
    repeat (3) @(negedge clk);
    check("R1 rspValid in reset", {7'd0, rspValid1}, 8'd0);
    check("R1 rspCode in reset", {3'd0, rspCode1}, 8'd0);
    check("R1 target/syndrome in reset", {rspTarget1, rspSyndrome1}, 8'd0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R4..R13 outcomes for both option settings
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      request(HIT, v[31:30], v[29:18]);
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      check({tag, " R2 valid"}, {7'd0, rspValid1}, 8'd1);
      check({tag, " code opt1"}, {3'd0, rspCode1}, {3'd0, v[17:13]});
      check({tag, " target opt1"}, {6'd0, rspTarget1}, {6'd0, v[12:11]});
      check({tag, " R12 syndrome opt1"}, {2'd0, rspSyndrome1}, {2'd0, synOf(v[17:13])});
      check({tag, " code opt0"}, {3'd0, rspCode0}, {3'd0, v[10:6]});
      check({tag, " target opt0"}, {6'd0, rspTarget0}, {6'd0, v[5:4]});
      check({tag, " R12 syndrome opt0"}, {2'd0, rspSyndrome0}, {2'd0, synOf(v[10:6])});
    end

    // R2: outputs hold with no request while inputs change
    request(HIT, 2'd1, 12'b001100011000);   // trap to EL1
    setFlags(2'd0, 12'b000000000000);
    reqEnc = 16'h0000;
    @(negedge clk);
    check("R2 valid drops", {7'd0, rspValid1}, 8'd0);
    check("R2 code holds", {3'd0, rspCode1}, {3'd0, CT});
    @(negedge clk);
    check("R2 target holds", {6'd0, rspTarget1}, 8'd1);
    check("R2 syndrome holds", {2'd0, rspSyndrome1}, 8'h18);

    // R3: encodings that differ in one field do not match
    request(HIT ^ 16'h0001, 2'd1, 12'b001100111000);  // op2
    check("R3 op2 differs", {3'd0, rspCode1}, {3'd0, CN});
    check("R3 syndrome zero", {rspTarget1, rspSyndrome1}, 8'd0);
    request(HIT ^ 16'h0008, 2'd0, 12'b001100111000);  // CRm, from EL0
    check("R3 CRm differs at EL0", {3'd0, rspCode1}, {3'd0, CN});
    request(HIT ^ 16'h4000, 2'd1, 12'b001100011000);  // op0, would trap
    check("R3 op0 differs", {3'd0, rspCode1}, {3'd0, CN});
    check("R3 no trap target", {rspTarget1, rspSyndrome1}, 8'd0);
    request(HIT ^ 16'h0800, 2'd3, 12'b001100110000);  // op1
    check("R3 op1 differs", {3'd0, rspCode0}, {3'd0, CN});

    // R1: reset mid-run clears a trap response
    request(HIT, 2'd3, 12'b001100110000);
    check("R11 trap before reset", {6'd0, rspTarget1}, 8'd3);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 code cleared", {3'd0, rspCode1}, 8'd0);
    check("R1 target/syndrome cleared", {rspTarget1, rspSyndrome1}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule